// File: doc/BRIEF.md
# Watchdog Reset Generator with Shared Prescaler

This block is a watchdog that runs from the base oscillator clock. A free-running prescaler drives a small watchdog counter. If software does not service the watchdog in time, the block issues a reset pulse of fixed length and latches a sticky flag that records a watchdog reset as the cause. Software services the watchdog by writing any value to one fixed bus address. That write clears the watchdog counter and the upper stages of the shared prescaler. The four lowest prescaler stages keep counting through the write, so the timeout measured from a service write depends slightly on the phase of those stages.

A rate input selects one of two timeouts. In the long rate the full prescaler plus watchdog chain must reach its terminal value. In the short rate a tap one bit above the prescaler is used. In both rates the terminal value is the tap's top count less sixteen, which makes both timeouts exact when the service write lands with the low stages at zero. A disable input blocks all watchdog resets. A stop-mode strobe clears the whole prescaler. An internal-reset input clears the whole chain. A power-on interval of fixed length follows the release of the asynchronous reset, and the chain is held at zero for all of that interval. A read of the service address returns a constant byte given as a parameter.

Top module: `wdt_core`

## Requirements
- R1: While `rst_n` is low, `wd_rst` and `cause_flag` are 0, `rst_pin_n` is 1 and `por_active` is 1.
- R2: `por_active` falls exactly POR_CYCLES+2 clock edges after `rst_n` rises (two edges of reset synchronizer, then the count). The chain is zero at that edge, so with no service `wd_rst` rises TERM+1 edges later.
- R3: With `rate_short`=0, TERM = 2^(PRE_W+WD_W) − 16 (262128 by default). If a service write is sampled while the four low prescaler stages read 0, `wd_rst` goes high exactly TERM edges after that sampling edge.
- R4: With `rate_short`=1, TERM = 2^(PRE_W+1) − 16 (8176 by default), with the same timing rule as R3.
- R5: A service write clears the watchdog counter and the prescaler bits at and above bit 4. The low four bits keep counting. If the write is sampled while they read L, `wd_rst` rises TERM + 1 − ((L+1) mod 16) edges later. For L = 15 this is TERM+1.
- R6: A service write sampled one edge before the terminal count would be reached prevents the reset.
- R7: Each watchdog reset holds `wd_rst` high for exactly PULSE_LEN cycles. A service write during the pulse neither shortens nor restarts it.
- R8: `rst_pin_n` is driven low during the pulse only when `pin_en` is 1. Otherwise it stays high.
- R9: While `wd_disable` is 1, no watchdog reset starts.
- R10: `cause_flag` is set when a pulse starts. It stays set through internal resets and service writes. Only a `cause_clr` pulse or `rst_n` clears it.
- R11: A `stop_req` strobe clears the whole prescaler (bits below PRE_W) but keeps the watchdog counter.
- R12: An `int_rst` strobe clears both the prescaler and the watchdog counter, so `wd_rst` rises TERM+1 edges after it.
- R13: `bus_rd_data` equals VEC_LO when `bus_addr` equals SVC_ADDR, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| int_rst | input | 1 | Internal reset strobe, clears the whole chain |
| stop_req | input | 1 | Stop-mode strobe, clears the prescaler |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd_data | output | 8 | Constant read data at the service address |
| rate_short | input | 1 | 1 selects the short timeout |
| wd_disable | input | 1 | 1 blocks watchdog resets |
| pin_en | input | 1 | 1 lets the pulse reach the reset pin |
| cause_clr | input | 1 | Clears the sticky cause flag |
| rst_pin_n | output | 1 | Active-low reset pin drive |
| wd_rst | output | 1 | Internal watchdog reset pulse |
| cause_flag | output | 1 | Sticky watchdog-cause flag |
| por_active | output | 1 | High during the power-on interval |

## Verification
The checker assumes that every control input is sampled only on rising clock edges. It also assumes that the pulse and the cause flag are touched by nothing other than the power-on reset, the clear strobe and the block's own timeout. The properties on disable and pin gating therefore rely on those inputs being steady at the sampling edge. The bench changes every input on falling edges. It holds `wd_disable` and `pin_en` steady across each terminal count and pulse it observes. It places every service, stop and internal-reset strobe at a computed chain phase, so the low prescaler value at the write is known exactly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    RATE_LONG  = 1'b0,
    RATE_SHORT = 1'b1
  } wdt_rate_e;

  // Bits needed to hold the value n
  function automatic int unsigned cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  generate
    if (STAGES == 1) begin : g_one
      logic sync_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= 1'b0;
        else         sync_q <= 1'b1;
      end
      assign srst_n = sync_q;
    end else begin : g_many
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
      assign srst_n = sync_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/wdt_por.sv
module wdt_por #(
  parameter int unsigned POR_CYCLES = 4096
) (
  input  logic clk,
  input  logic srst_n,
  output logic por_active
);

  localparam int unsigned PW = wdt_pkg::cnt_w(POR_CYCLES);
  localparam logic [PW-1:0] POR_END = PW'(POR_CYCLES);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    por_active = (cnt_q != POR_END);
    cnt_en     = por_active;
    cnt_d      = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdt_chain.sv
module wdt_chain
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_W = 12,
  parameter int unsigned WD_W  = 6,
  parameter int unsigned LOW_W = 4
) (
  input  logic      clk,
  input  logic      srst_n,
  input  logic      hold,
  input  logic      svc,
  input  logic      stop,
  input  wdt_rate_e rate,
  input  logic      dis,
  output logic      fire
);

  localparam int unsigned CH_W    = PRE_W + WD_W;
  localparam int unsigned SHORT_K = PRE_W + 1;

  logic [CH_W-1:0] cnt_q, cnt_d;
  logic            low_zero, long_hit, short_hit, tap_hit;

  // Terminal count: every bit from LOW_W up to the tap is one, low bits zero
  always_comb begin
    low_zero  = (cnt_q[LOW_W-1:0] == '0);
    long_hit  = (&cnt_q[CH_W-1:LOW_W]) && low_zero;
    short_hit = (&cnt_q[SHORT_K-1:LOW_W]) && low_zero;
    tap_hit   = (rate == RATE_SHORT) ? short_hit : long_hit;
    fire      = tap_hit && !dis && !hold;
  end

  always_comb begin
    if (hold || fire) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CH_W'(1);
      if (svc) begin
        cnt_d              = '0;
        cnt_d[LOW_W-1:0]   = cnt_q[LOW_W-1:0] + LOW_W'(1);
      end
      if (stop) begin
        cnt_d[PRE_W-1:0] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_LEN = 32
) (
  input  logic clk,
  input  logic srst_n,
  input  logic fire,
  input  logic cause_clr,
  output logic wd_rst,
  output logic cause_flag
);

  localparam int unsigned PLW = wdt_pkg::cnt_w(PULSE_LEN);
  localparam logic [PLW-1:0] PLEN = PLW'(PULSE_LEN);

  logic [PLW-1:0] pls_q, pls_d;
  logic           pls_en;
  logic           cause_q, cause_d, cause_en;

  always_comb begin
    wd_rst   = (pls_q != '0);
    pls_en   = fire || wd_rst;
    pls_d    = fire ? PLEN : (pls_q - PLW'(1));
    cause_en = fire || cause_clr;
    cause_d  = fire;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     pls_q <= '0;
    else if (pls_en) pls_q <= pls_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       cause_q <= 1'b0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_flag = cause_q;

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_W       = 12,
  parameter int unsigned WD_W        = 6,
  parameter int unsigned LOW_W       = 4,
  parameter int unsigned PULSE_LEN   = 32,
  parameter int unsigned POR_CYCLES  = 4096,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] SVC_ADDR = '1,
  parameter logic [7:0]        VEC_LO   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_rst,
  input  logic              stop_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  output logic [7:0]        bus_rd_data,
  input  logic              rate_short,
  input  logic              wd_disable,
  input  logic              pin_en,
  input  logic              cause_clr,
  output logic              rst_pin_n,
  output logic              wd_rst,
  output logic              cause_flag,
  output logic              por_active
);

  logic srst_n;
  logic addr_hit, svc_hit, hold, fire;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wdt_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk        (clk),
    .srst_n     (srst_n),
    .por_active (por_active)
  );

  always_comb begin
    addr_hit    = (bus_addr == SVC_ADDR);
    svc_hit     = bus_wr && addr_hit;
    bus_rd_data = addr_hit ? VEC_LO : 8'h00;
    hold        = por_active || int_rst || wd_rst;
    rst_pin_n   = ~(wd_rst & pin_en);
  end

  wdt_chain #(.PRE_W(PRE_W), .WD_W(WD_W), .LOW_W(LOW_W)) u_chain (
    .clk    (clk),
    .srst_n (srst_n),
    .hold   (hold),
    .svc    (svc_hit),
    .stop   (stop_req),
    .rate   (wdt_rate_e'(rate_short)),
    .dis    (wd_disable),
    .fire   (fire)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk        (clk),
    .srst_n     (srst_n),
    .fire       (fire),
    .cause_clr  (cause_clr),
    .wd_rst     (wd_rst),
    .cause_flag (cause_flag)
  );

endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
  parameter int unsigned PULSE_LEN = 32
) (
  input logic clk,
  input logic rst_n,
  input logic wd_disable,
  input logic pin_en,
  input logic cause_clr,
  input logic wd_rst,
  input logic rst_pin_n,
  input logic cause_flag,
  input logic por_active
);

  localparam int unsigned RW = $clog2(PULSE_LEN + 2) + 1;

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (wd_rst) run_q <= run_q + RW'(1);
    else             run_q <= '0;
  end

  // R7: pulse length counted in the checker
  a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst) |-> (run_q == RW'(PULSE_LEN)));

  // R8: pin stays high without pin enable
  a_r8_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_en |-> rst_pin_n);

  // R9: no new pulse while disabled
  a_r9_no_fire_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_disable && !wd_rst) |=> !wd_rst);

  // R10: flag accompanies every pulse start
  a_r10_cause_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst) |-> cause_flag);

  // R10: flag is sticky without a clear
  a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_flag && !cause_clr) |=> cause_flag);

  // R2: nothing fires inside the power-on interval
  a_r2_quiet_in_por: assert property (@(posedge clk) disable iff (!rst_n)
    por_active |-> !wd_rst);

endmodule

bind wdt_core wdt_core_chk #(.PULSE_LEN(PULSE_LEN)) u_wdt_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wd_disable (wd_disable),
  .pin_en     (pin_en),
  .cause_clr  (cause_clr),
  .wd_rst     (wd_rst),
  .rst_pin_n  (rst_pin_n),
  .cause_flag (cause_flag),
  .por_active (por_active)
);

// File: tb/wdt_core_test.sv
`timescale 1ns/1ps
module wdt_core_test;

  localparam int PRE_W      = 8;
  localparam int WD_W       = 4;
  localparam int LOW_W      = 4;
  localparam int PULSE_LEN  = 32;
  localparam int POR_CYCLES = 64;
  localparam int ADDR_W     = 16;
  localparam logic [15:0] SVC = 16'hFFFF;
  localparam logic [7:0]  VEC = 8'h5A;
  localparam int TERM_L = (1 << (PRE_W + WD_W)) - (1 << LOW_W);
  localparam int TERM_S = (1 << (PRE_W + 1)) - (1 << LOW_W);

  logic clk = 1'b0;
  logic rst_n, int_rst, stop_req, bus_wr, rate_short, wd_disable, pin_en, cause_clr;
  logic [ADDR_W-1:0] bus_addr;
  logic [7:0] bus_rd_data;
  logic rst_pin_n, wd_rst, cause_flag, por_active;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wdt_core #(
    .PRE_W(PRE_W), .WD_W(WD_W), .LOW_W(LOW_W), .PULSE_LEN(PULSE_LEN),
    .POR_CYCLES(POR_CYCLES), .SYNC_STAGES(2), .ADDR_W(ADDR_W),
    .SVC_ADDR(SVC), .VEC_LO(VEC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .int_rst(int_rst), .stop_req(stop_req),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd_data(bus_rd_data),
    .rate_short(rate_short), .wd_disable(wd_disable), .pin_en(pin_en),
    .cause_clr(cause_clr), .rst_pin_n(rst_pin_n), .wd_rst(wd_rst),
    .cause_flag(cause_flag), .por_active(por_active)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Strobe helpers: called at a falling edge, sampled at the next rising edge
  task automatic do_int_rst();
    int_rst = 1'b1; @(negedge clk); int_rst = 1'b0;
  endtask
  task automatic do_service();
    bus_wr = 1'b1; @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic do_stop();
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
  endtask
  task automatic do_clr();
    cause_clr = 1'b1; @(negedge clk); cause_clr = 1'b0;
  endtask

  // Counts edges until the pulse starts, then its length
  task automatic expect_timeout(input int exp_d, input bit pin_low, input bit svc_mid,
                                input string tag);
    int n = 0;
    int len = 0;
    bit pin_bad = 1'b0;
    while (!wd_rst && n < exp_d + 40) begin
      @(negedge clk);
      n++;
    end
    check(n == exp_d, tag, n, exp_d);
    while (wd_rst && len < PULSE_LEN + 10) begin
      if (rst_pin_n != !pin_low) pin_bad = 1'b1;
      bus_wr = (svc_mid && len == 3);
      @(negedge clk);
      len++;
    end
    bus_wr = 1'b0;
    check(len == PULSE_LEN, "R7 pulse length", len, PULSE_LEN);
    check(!pin_bad, "R8 pin drive", pin_bad, 0);
  endtask

  task automatic t_reset_por();
    int n = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(wd_rst == 0 && cause_flag == 0, "R1 outputs low", {wd_rst, cause_flag}, 0);
    check(rst_pin_n == 1 && por_active == 1, "R1 pin and por", {rst_pin_n, por_active}, 3);
    rst_n = 1'b1;
    while (por_active && n < POR_CYCLES + 20) begin
      @(negedge clk);
      n++;
    end
    check(n == POR_CYCLES + 2, "R2 por length", n, POR_CYCLES + 2);
    expect_timeout(TERM_L + 1, 1'b1, 1'b0, "R2 chain zero after por");
    check(cause_flag == 1, "R10 flag set", cause_flag, 1);
    do_clr();
    check(cause_flag == 0, "R10 flag cleared", cause_flag, 0);
  endtask

  task automatic t_read();
    bus_addr = SVC; #1;
    check(bus_rd_data == VEC, "R13 read at service address", bus_rd_data, VEC);
    bus_addr = 16'h1234; #1;
    check(bus_rd_data == 8'h00, "R13 read elsewhere", bus_rd_data, 0);
    bus_addr = SVC;
    @(negedge clk);
  endtask

  task automatic t_long();
    rate_short = 1'b0;
    do_int_rst();
    do_service();
    expect_timeout(TERM_L, 1'b1, 1'b1, "R3 long timeout");
  endtask

  task automatic t_short();
    rate_short = 1'b1;
    do_int_rst();
    do_service();
    expect_timeout(TERM_S, 1'b1, 1'b0, "R4 short timeout");
  endtask

  task automatic t_phase();
    rate_short = 1'b1;
    do_int_rst();
    repeat (15) @(negedge clk);
    do_service();
    expect_timeout(TERM_S + 1, 1'b1, 1'b0, "R5 low stages at 15");
  endtask

  task automatic t_late_service();
    bit seen = 1'b0;
    rate_short = 1'b1;
    do_int_rst();
    do_service();
    for (int i = 0; i < TERM_S - 2; i++) begin
      if (wd_rst) seen = 1'b1;
      @(negedge clk);
    end
    do_service();
    if (wd_rst) seen = 1'b1;
    check(!seen, "R6 no reset with late service", seen, 0);
    expect_timeout(TERM_S + 1, 1'b1, 1'b0, "R6 next timeout");
  endtask

  task automatic t_pin_off();
    rate_short = 1'b1;
    pin_en = 1'b0;
    do_int_rst();
    do_service();
    expect_timeout(TERM_S, 1'b0, 1'b0, "R8 timeout with pin off");
    pin_en = 1'b1;
  endtask

  task automatic t_disable();
    bit seen = 1'b0;
    rate_short = 1'b1;
    wd_disable = 1'b1;
    do_int_rst();
    for (int i = 0; i < 2 * TERM_S + 40; i++) begin
      if (wd_rst || !rst_pin_n) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R9 disabled", seen, 0);
    do_int_rst();
    wd_disable = 1'b0;
  endtask

  task automatic t_stop();
    rate_short = 1'b0;
    do_int_rst();
    repeat (299) @(negedge clk);
    do_stop();
    expect_timeout(TERM_L - (1 << PRE_W) + 1, 1'b1, 1'b0, "R11 stop keeps watchdog");
  endtask

  task automatic t_int_rst();
    rate_short = 1'b1;
    do_int_rst();
    repeat (299) @(negedge clk);
    do_int_rst();
    expect_timeout(TERM_S + 1, 1'b1, 1'b0, "R12 internal reset");
    do_int_rst();
    do_service();
    check(cause_flag == 1, "R10 flag sticky", cause_flag, 1);
  endtask

  initial begin
    rst_n = 1'b0; int_rst = 1'b0; stop_req = 1'b0; bus_wr = 1'b0;
    rate_short = 1'b0; wd_disable = 1'b0; pin_en = 1'b1; cause_clr = 1'b0;
    bus_addr = SVC;
    @(negedge clk);
    t_reset_por();
    t_read();
    t_long();
    t_short();
    t_phase();
    t_late_service();
    t_pin_off();
    t_disable();
    t_stop();
    t_int_rst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule